// File: doc/BRIEF.md
# Triggered Burst Capture Streamer

The block turns one trigger event into exactly one bounded burst of complex samples on a 128-bit AXI4-Stream master port. The burst is meant for a stream-to-memory DMA engine. Each burst is a window of a runtime-chosen number of frames, and each frame holds 512 complex samples. Every beat carries four samples, and every sample is a 16-bit real part and a 16-bit imaginary part. Outside a burst the port stays silent: the block never streams continuously.

The frame count and the data source are captured when the trigger is accepted. The data source is either the live 128-bit sample input or a built-in counter pattern. In the counter pattern, each real field holds the sample's position inside its frame and each imaginary field holds the frame number. Downstream software can then confirm continuity, frame alignment and ordering. TLAST marks the final beat of the window. A busy flag covers the whole burst.

Top module: `burst_capture_streamer`

## Requirements
- R1: In each beat, lane k (k = 0..3) occupies bits [32k+31:32k]; within a lane the real part sits in the low 16 bits and the imaginary part in the high 16 bits.
- R2: In counter-pattern mode (mode input = 1 at trigger), the real field of lane k in beat b of a frame equals 4b+k, so it runs 0..511 and restarts at 0 on every frame; a frame is 128 beats.
- R3: In counter-pattern mode, the imaginary field of every lane equals the frame number within the burst, starting at 0 and rising by one per frame.
- R4: An accepted trigger with a frame count N in 1..1024 yields exactly N×128 accepted beats; TLAST is high on beat N×128−1 only, and TVALID falls after that beat is accepted.
- R5: While TVALID is high and TREADY is low, TDATA and TLAST stay unchanged; the burst advances by one beat only per accepted handshake.
- R6: A trigger that arrives during a burst has no effect: the running burst keeps its length and no second burst follows.
- R7: TVALID and busy both rise in the cycle after the accepted trigger edge, and busy stays high until the clock edge that accepts the last beat.
- R8: A trigger with a frame count of 0 produces no beats, and busy stays low.
- R9: In live mode (mode input = 0 at trigger), each beat equals the live input sampled at the edge where the beat is loaded: the trigger edge for beat 0 and the accept edge of the previous beat for later beats. Mode and frame count are latched at the trigger, and later changes do not affect the running burst.
- R10: Synchronous active-high reset, even in the middle of a burst, returns the block to idle with TVALID, TLAST and busy low, and the next burst starts again from frame 0, sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Capture trigger, sampled each clock |
| frames_cfg_i | input | 11 | Frames per burst, 0..1024 |
| test_mode_i | input | 1 | 1 selects the counter pattern, 0 selects live data |
| live_data_i | input | 128 | Live packed samples, four per word |
| m_tdata | output | 128 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the consumer |
| m_tlast | output | 1 | End-of-burst marker |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
The counter pattern is swept across bursts of 1, 2 and 1024 frames. A wrong lane order, a sample counter that fails to wrap at 512, or a frame index that slips shows up as a mismatch at a known beat. Live bursts use a beat-dependent input word that changes only on accepted handshakes, so a loaded value taken one edge early or late is exposed. Ready patterns that are always high, alternating, and pseudo-random separate stall holding from beat advancement. Extra cases cover a zero-frame trigger, a retrigger and a mode and count change in mid-burst, and a reset in mid-burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Sample format on the stream
    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;
    localparam int LANE_W   = 2 * SAMPLE_W;
    localparam int BEAT_W   = LANES * LANE_W;

    // Default burst geometry
    localparam int DEF_FRAME_SAMPLES = 512;
    localparam int DEF_MAX_FRAMES    = 1024;

    typedef struct packed {
        logic [SAMPLE_W-1:0] im;
        logic [SAMPLE_W-1:0] re;
    } cplx_t;

    typedef cplx_t [LANES-1:0] beat_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } arm_state_t;

    // Counter-pattern lane value for a given beat-in-frame and frame number
    function automatic cplx_t pattern_lane(input int beat_idx, input int frame_idx,
                                           input int lane);
        cplx_t c;
        c.re = SAMPLE_W'(beat_idx * LANES + lane);
        c.im = SAMPLE_W'(frame_idx);
        return c;
    endfunction

endpackage

// File: rtl/bcs_arm_ctrl.sv
module bcs_arm_ctrl
    import bcs_pkg::*;
#(
    parameter int FRAMES_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic [FRAMES_W-1:0] frames_cfg,
    input  logic                test_mode,
    input  logic                final_accept,
    output logic                start,
    output logic                busy,
    output logic [FRAMES_W-1:0] nfr_q,
    output logic                test_q
);

    arm_state_t state_q;

    always_comb begin
        start = (state_q == ST_IDLE) && trig && (frames_cfg != '0);
        busy  = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            nfr_q   <= '0;
            test_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        nfr_q   <= frames_cfg;
                        test_q  <= test_mode;
                    end
                end
                ST_RUN: begin
                    if (final_accept) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_zero_frames_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && trig && frames_cfg == '0) |=> (state_q == ST_IDLE));

    p_retrigger_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !final_accept) |=>
            (state_q == ST_RUN && $stable(nfr_q) && $stable(test_q)));

    p_count_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (nfr_q != '0));

endmodule

// File: rtl/bcs_position.sv
module bcs_position #(
    parameter int BEATS_PER_FRAME = 128,
    parameter int MAX_FRAMES      = 1024,
    parameter int FRAMES_W        = 11,
    localparam int BW = $clog2(BEATS_PER_FRAME),
    localparam int FW = $clog2(MAX_FRAMES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                advance,
    input  logic                active,
    input  logic [FRAMES_W-1:0] nfr_q,
    output logic [BW-1:0]       beat_q,
    output logic [FW-1:0]       frame_q,
    output logic [BW-1:0]       next_beat,
    output logic [FW-1:0]       next_frame,
    output logic                at_final
);

    logic frame_end;

    always_comb begin
        frame_end = (beat_q == BW'(BEATS_PER_FRAME - 1));
        if (frame_end) begin
            next_beat  = '0;
            next_frame = frame_q + FW'(1);
        end else begin
            next_beat  = beat_q + BW'(1);
            next_frame = frame_q;
        end
        at_final = frame_end && (FRAMES_W'(frame_q) == nfr_q - FRAMES_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            beat_q  <= '0;
            frame_q <= '0;
        end else if (advance) begin
            beat_q  <= next_beat;
            frame_q <= next_frame;
        end
    end

    p_frame_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        active |-> (FRAMES_W'(frame_q) < nfr_q));

    p_advance_on_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (!advance && !start) |=> ($stable(beat_q) && $stable(frame_q)));

endmodule

// File: rtl/bcs_beat_builder.sv
module bcs_beat_builder
    import bcs_pkg::*;
#(
    parameter int BEATS_PER_FRAME = 128,
    parameter int MAX_FRAMES      = 1024,
    localparam int BW = $clog2(BEATS_PER_FRAME),
    localparam int FW = $clog2(MAX_FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load,
    input  logic              drop,
    input  logic              ready,
    input  logic              test_sel,
    input  logic [BW-1:0]     ld_beat,
    input  logic [FW-1:0]     ld_frame,
    input  logic [BEAT_W-1:0] live_data,
    output logic [BEAT_W-1:0] data_q,
    output logic              valid_q
);

    beat_t pat;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_comb pat[l] = pattern_lane(int'(ld_beat), int'(ld_frame), l);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (load) data_q <= test_sel ? BEAT_W'(pat) : live_data;
            if (start)     valid_q <= 1'b1;
            else if (drop) valid_q <= 1'b0;
        end
    end

    p_hold_under_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready) |=> (valid_q && $stable(data_q)));

    p_no_load_when_stalled_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready) |-> !load);

endmodule

// File: rtl/burst_capture_streamer.sv
module burst_capture_streamer
    import bcs_pkg::*;
#(
    parameter int FRAME_SAMPLES = DEF_FRAME_SAMPLES,
    parameter int MAX_FRAMES    = DEF_MAX_FRAMES,
    localparam int BEATS_PER_FRAME = FRAME_SAMPLES / LANES,
    localparam int BW       = $clog2(BEATS_PER_FRAME),
    localparam int FW       = $clog2(MAX_FRAMES),
    localparam int FRAMES_W = $clog2(MAX_FRAMES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_i,
    input  logic [FRAMES_W-1:0] frames_cfg_i,
    input  logic                test_mode_i,
    input  logic [BEAT_W-1:0]   live_data_i,
    output logic [BEAT_W-1:0]   m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tlast,
    output logic                busy_o
);

    logic                start, busy, test_q, at_final;
    logic                accept, final_accept, advance, load;
    logic [FRAMES_W-1:0] nfr_q;
    logic [BW-1:0]       beat_q, next_beat, ld_beat;
    logic [FW-1:0]       frame_q, next_frame, ld_frame;
    logic                ld_test;

    always_comb begin
        accept       = m_tvalid && m_tready;
        final_accept = accept && at_final;
        advance      = accept && !at_final;
        load         = start || advance;
        ld_beat      = start ? '0 : next_beat;
        ld_frame     = start ? '0 : next_frame;
        ld_test      = start ? test_mode_i : test_q;
        m_tlast      = m_tvalid && at_final;
        busy_o       = busy;
    end

    bcs_arm_ctrl #(
        .FRAMES_W (FRAMES_W)
    ) u_arm (
        .clk          (clk),
        .rst          (rst),
        .trig         (trig_i),
        .frames_cfg   (frames_cfg_i),
        .test_mode    (test_mode_i),
        .final_accept (final_accept),
        .start        (start),
        .busy         (busy),
        .nfr_q        (nfr_q),
        .test_q       (test_q)
    );

    bcs_position #(
        .BEATS_PER_FRAME (BEATS_PER_FRAME),
        .MAX_FRAMES      (MAX_FRAMES),
        .FRAMES_W        (FRAMES_W)
    ) u_pos (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .advance    (advance),
        .active     (busy),
        .nfr_q      (nfr_q),
        .beat_q     (beat_q),
        .frame_q    (frame_q),
        .next_beat  (next_beat),
        .next_frame (next_frame),
        .at_final   (at_final)
    );

    bcs_beat_builder #(
        .BEATS_PER_FRAME (BEATS_PER_FRAME),
        .MAX_FRAMES      (MAX_FRAMES)
    ) u_build (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load      (load),
        .drop      (final_accept),
        .ready     (m_tready),
        .test_sel  (ld_test),
        .ld_beat   (ld_beat),
        .ld_frame  (ld_frame),
        .live_data (live_data_i),
        .data_q    (m_tdata),
        .valid_q   (m_tvalid)
    );

    p_last_ends_burst_r4: assert property (@(posedge clk) disable iff (rst)
        final_accept |=> (!busy_o && !m_tvalid));

    p_valid_within_busy_r7: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> busy_o);

    p_busy_has_valid_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> m_tvalid);

    p_start_raises_both_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy_o && m_tvalid && beat_q == '0 && frame_q == '0));

    p_last_held_r5: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> $stable(m_tlast));

endmodule

// File: tb/burst_capture_streamer_tb_top.sv
module burst_capture_streamer_tb_top;

    localparam int BPF = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig_i = 1'b0;
    logic [10:0]  frames_cfg_i = '0;
    logic         test_mode_i = 1'b0;
    logic [127:0] live_data_i = '0;
    logic [127:0] m_tdata;
    logic         m_tvalid;
    logic         m_tready = 1'b0;
    logic         m_tlast;
    logic         busy_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    burst_capture_streamer dut_i (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig_i),
        .frames_cfg_i (frames_cfg_i),
        .test_mode_i  (test_mode_i),
        .live_data_i  (live_data_i),
        .m_tdata      (m_tdata),
        .m_tvalid     (m_tvalid),
        .m_tready     (m_tready),
        .m_tlast      (m_tlast),
        .busy_o       (busy_o)
    );

    function automatic logic [127:0] live_word(input int n);
        logic [31:0] a, b, c, d;
        a = 32'(n) * 32'h9E3779B1;
        b = ~32'(n);
        c = (32'(n) << 8) ^ 32'h00005A5A;
        d = 32'(n) + 32'h00001000;
        return {a, b, c, d};
    endfunction

    // R1 lane layout, R2 real = 4b+k, R3 imag = frame
    function automatic logic [127:0] pat_word(input int n);
        logic [127:0] w;
        int b, f;
        b = n % BPF;
        f = n / BPF;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            w[32*k +: 16]      = 16'(4*b + k);
            w[32*k + 16 +: 16] = 16'(f);
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready pattern: 0 always, 1 alternate, 2 pseudo-random
    task automatic pick_ready(input int pat);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (pat)
            0:       m_tready = 1'b1;
            1:       m_tready = cyc[0];
            default: m_tready = lfsr[0] | lfsr[3];
        endcase
    endtask

    task automatic run_burst(input int nfr, input bit test, input int rpat,
                             input bit retrig, input bit change_cfg);
        int n, limit;
        logic [127:0] exp, prev;
        bit stalled;
        limit = nfr * BPF;
        m_tready = 1'b0;
        live_data_i = live_word(0);
        frames_cfg_i = 11'(nfr);
        test_mode_i = test;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        if (change_cfg) begin
            // R9: mode and count latched at trigger
            test_mode_i = ~test;
            frames_cfg_i = 11'(nfr + 3);
        end
        n = 0;
        stalled = 1'b0;
        prev = '0;
        while (n < limit) begin
            exp = test ? pat_word(n) : live_word(n);
            // R1 R2 R3 R9: beat content; R4: TLAST position; R7: valid and busy
            check(m_tvalid && busy_o && m_tdata == exp &&
                  m_tlast == (n == limit - 1),
                  test ? "R2/R3 beat pattern, R4 last, R7 busy" :
                         "R9 live beat, R4 last, R7 busy",
                  {m_tdata[126:0], m_tlast}, {exp[126:0], 1'b1 & (n == limit - 1)});
            if (stalled)
                check(m_tdata == prev, "R5 hold under stall", m_tdata, prev);
            prev = m_tdata;
            pick_ready(rpat);
            trig_i = (retrig && n == limit / 2) ? 1'b1 : 1'b0;
            stalled = !m_tready;
            if (m_tready) begin
                n++;
                if (!test) live_data_i = live_word(n);
            end
            @(negedge clk);
        end
        trig_i = 1'b0;
        m_tready = 1'b1;
        // R7 R4: busy and valid drop right after the final accept
        check(!busy_o && !m_tvalid && !m_tlast, "R4/R7 idle after last beat",
              {125'd0, busy_o, m_tvalid, m_tlast}, '0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            // R6 R4: no extra beats
            check(!busy_o && !m_tvalid, "R6 no beats after burst",
                  {126'd0, busy_o, m_tvalid}, '0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(!m_tvalid && !busy_o && !m_tlast, "R10 reset state",
              {125'd0, m_tvalid, busy_o, m_tlast}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R8: zero frames
        frames_cfg_i = '0;
        test_mode_i = 1'b1;
        trig_i = 1'b1;
        m_tready = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check(!m_tvalid && !busy_o, "R8 zero frames no beats",
                  {126'd0, m_tvalid, busy_o}, '0);
            @(negedge clk);
        end

        run_burst(1, 1'b1, 0, 1'b0, 1'b0);
        run_burst(2, 1'b1, 1, 1'b1, 1'b1);   // R6 retrigger, R9 latching
        run_burst(3, 1'b0, 2, 1'b0, 1'b0);   // R9 live, R5 random stalls
        run_burst(2, 1'b0, 1, 1'b1, 1'b1);

        // R10: reset in mid-burst
        frames_cfg_i = 11'd3;
        test_mode_i = 1'b1;
        trig_i = 1'b1;
        m_tready = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!m_tvalid && !busy_o && !m_tlast, "R10 reset mid-burst",
              {125'd0, m_tvalid, busy_o, m_tlast}, '0);
        rst = 1'b0;
        @(negedge clk);
        run_burst(1, 1'b1, 2, 1'b0, 1'b0);   // R10 restarts at frame 0 sample 0

        run_burst(1024, 1'b1, 0, 1'b0, 1'b0); // R4 largest count

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule